// File: doc/BRIEF.md
# USB Host Controller Power-State Manager

This block sits next to the register interface of a USB host controller and decides what the controller may do in its current power state. Software sets a two-bit device power state through a small configuration port. Only two codes are legal: full-on (`00`) and off (`11`). A write of either code takes effect on the next clock edge. The two other codes are accepted on the port, but the stored value does not change. When software moves the controller from off back to full-on, the block sends a one-cycle reset pulse to the controller core.

In the off state the block ends every memory-mapped register request, including requests from the debug-port source, with an abort response instead of an acknowledge. It also holds the controller interrupt low, and it reports wake events on a separate level output that software clears. In both states a software pause bit stops the DMA channels from being granted new memory requests. A grant already issued still completes. Frame-start pulses and the frame number keep running regardless of the pause bit or the power state.

Top module: `usbh_pm`

## Requirements
- R1: After reset, the power state reads `00`, the pause bit is clear, and `ctl_rst`, `irq_out`, `pme_out`, `mmio_ack`, `mmio_abort`, `dma_gnt` and `sof_out` are low.
- R2: A configuration write to address 0 with bits [1:0] equal to `00` or `11` loads that code into the power state at the next edge. A write of `01` or `10` leaves the power state unchanged. Only `00` and `11` are ever held.
- R3: A write of `00` while the state is `11` raises `ctl_rst` for exactly the one cycle after the write edge. A write of `00` while the state is `00`, and a write of `11`, raise no pulse.
- R4: Each bit of `mmio_req` is answered one cycle later. The answer is on `mmio_ack` if the power state after that edge is `00`, and on `mmio_abort` if it is `11`. Bit 1 is the debug-port source and follows the same rule.
- R5: `irq_out` equals `irq_raw` delayed by one cycle while the power state is `00`. It is never high while the state is `11`.
- R6: `wake_evt` in the off state sets `pme_out` at the next edge. `pme_out` then holds until a configuration write to address 1 with bit 0 set clears it, or until the state returns to `00`. `wake_evt` has no effect in the full-on state.
- R7: Address 1 bit 2 is the pause bit. While it is set, no new `dma_gnt` pulse is issued. A channel granted before the pause finishes when its `dma_done` arrives. Pending requests are granted after the pause bit is cleared. Each grant is a one-cycle pulse issued one edge after the request, and a channel is not regranted until its done.
- R8: `dma_paused` is high exactly when the pause bit is set and no channel has an outstanding grant.
- R9: `sof_out` is `sof_tick` delayed by one cycle, and `frame_num` advances by one on each tick, wrapping modulo 2^FRAME_W. Neither the pause bit nor the power state affects them.
- R10: A configuration read returns data on `cfg_rdata` one cycle later. Address 0 gives the power state in bits [1:0]. Address 1 gives the wake-pending bit in bit 0, the paused status in bit 1 and the pause bit in bit 2. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low global reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 1 | Configuration register select (0 power, 1 status/control) |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data, one cycle after the read |
| mmio_req | input | NSRC | Register access requests; bit 1 is the debug source |
| mmio_ack | output | NSRC | Access serviced |
| mmio_abort | output | NSRC | Access terminated with an abort |
| irq_raw | input | 1 | Raw controller interrupt |
| irq_out | output | 1 | Gated interrupt |
| wake_evt | input | 1 | Wake event |
| pme_out | output | 1 | Power-management event level |
| dma_req | input | NDMA | DMA channel requests |
| dma_done | input | NDMA | DMA channel completions |
| dma_gnt | output | NDMA | DMA grant pulses |
| dma_paused | output | 1 | Pause is in effect and no grant is outstanding |
| sof_tick | input | 1 | Frame timer tick |
| sof_out | output | 1 | Frame-start pulse |
| frame_num | output | FRAME_W | Frame counter |
| pwr_state | output | 2 | Current power state |
| ctl_rst | output | 1 | Controller reset pulse |

## Verification
On every cycle the assertions check these rules:
- The power state only ever holds a legal code.
- Writes of the illegal codes leave the state untouched.
- The wake reset follows an accepted off-to-on write and lasts a single cycle.
- The interrupt and the wake level stay inside the power state that allows them.
- No grant follows a cycle with pause set.
- Frame-start pulses track the tick.

Some behaviour depends on sequences, and only the bench scenarios show it:
- A granted transfer completes across a pause.
- Stalled requests are released once the pause clears.
- The wake level holds until a write-one-to-clear.
- The frame counter wraps.
- The read-back layout is correct.

// File: rtl/usbh_pm_pkg.sv
package usbh_pm_pkg;

    typedef enum logic [1:0] {
        PWR_ON  = 2'b00,
        PWR_OFF = 2'b11
    } pwr_e;

    localparam logic ADDR_PWR  = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    localparam int STAT_PME_BIT    = 0;
    localparam int STAT_PAUSED_BIT = 1;
    localparam int STAT_PAUSE_BIT  = 2;

    typedef struct packed {
        pwr_e pwr;
        logic rst;
        logic pme;
    } pm_state_t;

endpackage

// File: rtl/usbh_pm_state.sv
module usbh_pm_state
    import usbh_pm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_pwr,
    input  logic       wr_stat,
    input  logic [1:0] code,
    input  logic       clr_pme,
    input  logic       wake_evt,
    output pwr_e       pwr_cur,
    output pwr_e       pwr_nxt,
    output logic       rst_pulse,
    output logic       pme
);
    pm_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.rst = 1'b0;
        if (wr_pwr) begin
            case (code)
                2'b00: begin
                    if (st_q.pwr == PWR_OFF) st_d.rst = 1'b1;
                    st_d.pwr = PWR_ON;
                end
                2'b11:   st_d.pwr = PWR_OFF;
                default: st_d.pwr = st_q.pwr;
            endcase
        end
        if (st_d.pwr == PWR_ON) begin
            st_d.pme = 1'b0;
        end else if (wake_evt) begin
            st_d.pme = 1'b1;
        end else if (wr_stat && clr_pme) begin
            st_d.pme = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pwr: PWR_ON, rst: 1'b0, pme: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pwr_cur   = st_q.pwr;
    assign pwr_nxt   = st_d.pwr;
    assign rst_pulse = st_q.rst;
    assign pme       = st_q.pme;
endmodule

// File: rtl/usbh_pm_gate.sv
module usbh_pm_gate
    import usbh_pm_pkg::*;
#(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  pwr_e            pwr_nxt,
    input  logic [NSRC-1:0] req,
    input  logic            irq_raw,
    output logic [NSRC-1:0] ack,
    output logic [NSRC-1:0] abt,
    output logic            irq
);
    typedef struct packed {
        logic [NSRC-1:0] ack;
        logic [NSRC-1:0] abt;
        logic            irq;
    } gate_t;

    gate_t g_d, g_q;
    logic  on_nxt;

    assign on_nxt = (pwr_nxt == PWR_ON);

    always_comb begin
        g_d     = '0;
        g_d.irq = irq_raw && on_nxt;
        for (int i = 0; i < NSRC; i++) begin
            g_d.ack[i] = req[i] && on_nxt;
            g_d.abt[i] = req[i] && !on_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign ack = g_q.ack;
    assign abt = g_q.abt;
    assign irq = g_q.irq;
endmodule

// File: rtl/usbh_pm_dma.sv
module usbh_pm_dma #(
    parameter int NDMA = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_stat,
    input  logic            pause_wdata,
    input  logic [NDMA-1:0] req,
    input  logic [NDMA-1:0] done,
    output logic [NDMA-1:0] gnt,
    output logic            pause,
    output logic            paused
);
    typedef struct packed {
        logic            pause;
        logic [NDMA-1:0] busy;
        logic [NDMA-1:0] gnt;
    } dma_t;

    dma_t d_d, d_q;

    always_comb begin
        d_d       = d_q;
        d_d.pause = wr_stat ? pause_wdata : d_q.pause;
        for (int i = 0; i < NDMA; i++) begin
            d_d.gnt[i]  = req[i] && !d_q.busy[i] && !d_q.pause;
            d_d.busy[i] = (d_q.busy[i] && !done[i]) || d_d.gnt[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign gnt    = d_q.gnt;
    assign pause  = d_q.pause;
    assign paused = d_q.pause && (d_q.busy == '0);
endmodule

// File: rtl/usbh_pm_frame.sv
module usbh_pm_frame #(
    parameter int FRAME_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    output logic               sof,
    output logic [FRAME_W-1:0] fnum
);
    typedef struct packed {
        logic               sof;
        logic [FRAME_W-1:0] fnum;
    } frm_t;

    frm_t f_d, f_q;

    always_comb begin
        f_d     = f_q;
        f_d.sof = tick;
        if (tick) f_d.fnum = f_q.fnum + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign sof  = f_q.sof;
    assign fnum = f_q.fnum;
endmodule

// File: rtl/usbh_pm.sv
module usbh_pm
    import usbh_pm_pkg::*;
#(
    parameter int NSRC    = 2,
    parameter int NDMA    = 4,
    parameter int FRAME_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic               cfg_rd,
    input  logic               cfg_addr,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rdata,
    input  logic [NSRC-1:0]    mmio_req,
    output logic [NSRC-1:0]    mmio_ack,
    output logic [NSRC-1:0]    mmio_abort,
    input  logic               irq_raw,
    output logic               irq_out,
    input  logic               wake_evt,
    output logic               pme_out,
    input  logic [NDMA-1:0]    dma_req,
    input  logic [NDMA-1:0]    dma_done,
    output logic [NDMA-1:0]    dma_gnt,
    output logic               dma_paused,
    input  logic               sof_tick,
    output logic               sof_out,
    output logic [FRAME_W-1:0] frame_num,
    output logic [1:0]         pwr_state,
    output logic               ctl_rst
);
    logic wr_pwr, wr_stat, pause_ctl;
    pwr_e pwr_cur, pwr_nxt;
    logic [7:0] rdata_d, rdata_q;
    logic unused_wdata;

    assign unused_wdata = ^cfg_wdata[7:3];
    assign wr_pwr  = cfg_wr && (cfg_addr == ADDR_PWR);
    assign wr_stat = cfg_wr && (cfg_addr == ADDR_STAT);

    usbh_pm_state u_state (
        .clk(clk), .rst_n(rst_n), .wr_pwr(wr_pwr), .wr_stat(wr_stat),
        .code(cfg_wdata[1:0]), .clr_pme(cfg_wdata[STAT_PME_BIT]),
        .wake_evt(wake_evt), .pwr_cur(pwr_cur), .pwr_nxt(pwr_nxt),
        .rst_pulse(ctl_rst), .pme(pme_out)
    );

    usbh_pm_gate #(.NSRC(NSRC)) u_gate (
        .clk(clk), .rst_n(rst_n), .pwr_nxt(pwr_nxt), .req(mmio_req),
        .irq_raw(irq_raw), .ack(mmio_ack), .abt(mmio_abort), .irq(irq_out)
    );

    usbh_pm_dma #(.NDMA(NDMA)) u_dma (
        .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat),
        .pause_wdata(cfg_wdata[STAT_PAUSE_BIT]), .req(dma_req),
        .done(dma_done), .gnt(dma_gnt), .pause(pause_ctl), .paused(dma_paused)
    );

    usbh_pm_frame #(.FRAME_W(FRAME_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(sof_tick), .sof(sof_out), .fnum(frame_num)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (cfg_rd) begin
            rdata_d = '0;
            if (cfg_addr == ADDR_PWR) begin
                rdata_d[1:0] = pwr_cur;
            end else begin
                rdata_d[STAT_PME_BIT]    = pme_out;
                rdata_d[STAT_PAUSED_BIT] = dma_paused;
                rdata_d[STAT_PAUSE_BIT]  = pause_ctl;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign cfg_rdata = rdata_q;
    assign pwr_state = pwr_cur;
endmodule

// File: rtl/usbh_pm_chk.sv
module usbh_pm_chk #(
    parameter int NSRC = 2,
    parameter int NDMA = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_wr,
    input logic            cfg_addr,
    input logic [7:0]      cfg_wdata,
    input logic [1:0]      pwr_state,
    input logic            ctl_rst,
    input logic            irq_out,
    input logic            pme_out,
    input logic [NSRC-1:0] mmio_ack,
    input logic [NSRC-1:0] mmio_abort,
    input logic [NDMA-1:0] dma_gnt,
    input logic            pause_ctl,
    input logic            sof_tick,
    input logic            sof_out
);
    p_legal_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'b00) || (pwr_state == 2'b11));

    p_illegal_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_addr && (cfg_wdata[1:0] == 2'b01 || cfg_wdata[1:0] == 2'b10))
        |=> $stable(pwr_state));

    p_wake_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_addr && cfg_wdata[1:0] == 2'b00 && pwr_state == 2'b11) |=> ctl_rst);

    p_reset_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rst |=> !ctl_rst);

    p_ack_on_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mmio_ack != '0) |-> (pwr_state == 2'b00));

    p_no_ack_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mmio_ack & mmio_abort) == '0);

    p_irq_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'b11) |-> !irq_out);

    p_pme_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pme_out |-> (pwr_state == 2'b11));

    p_no_grant_paused_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pause_ctl |=> (dma_gnt == '0));

    p_sof_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sof_tick |=> sof_out);

    p_sof_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_tick |=> !sof_out);
endmodule

bind usbh_pm usbh_pm_chk #(.NSRC(NSRC), .NDMA(NDMA)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pwr_state(pwr_state), .ctl_rst(ctl_rst),
    .irq_out(irq_out), .pme_out(pme_out), .mmio_ack(mmio_ack),
    .mmio_abort(mmio_abort), .dma_gnt(dma_gnt), .pause_ctl(pause_ctl),
    .sof_tick(sof_tick), .sof_out(sof_out)
);

// File: tb/usbh_pm_test.sv
`timescale 1ns/1ps
module usbh_pm_test;
    localparam int NSRC = 2, NDMA = 4, FRAME_W = 11;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_wr = 0, cfg_rd = 0, cfg_addr = 0;
    logic [7:0] cfg_wdata = 0, cfg_rdata;
    logic [NSRC-1:0] mmio_req = 0, mmio_ack, mmio_abort;
    logic irq_raw = 0, irq_out, wake_evt = 0, pme_out;
    logic [NDMA-1:0] dma_req = 0, dma_done = 0, dma_gnt;
    logic dma_paused, sof_tick = 0, sof_out, ctl_rst;
    logic [FRAME_W-1:0] frame_num;
    logic [1:0] pwr_state;

    int checks = 0, failures = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    usbh_pm #(.NSRC(NSRC), .NDMA(NDMA), .FRAME_W(FRAME_W)) uut (.*);

    function automatic logic [1:0] next_pwr(logic [1:0] cur, logic wr, logic [1:0] code);
        if (wr && (code == 2'b00 || code == 2'b11)) return code;
        return cur;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic cfg_write(logic a, logic [7:0] d);
        cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_wr = 0; cfg_wdata = 0;
    endtask

    task automatic cfg_read(logic a, output logic [7:0] d);
        cfg_rd = 1; cfg_addr = a;
        step();
        cfg_rd = 0;
        d = cfg_rdata;
    endtask

    initial begin
        #1_000_000;
        if (!done_flag) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [1:0] model, nxt;
        logic [FRAME_W-1:0] f0;
        void'($urandom(32'd4711));
        step(); step();
        rst_n = 1;
        step();

        // R1 reset state
        chk("R1 reset outputs",
            {pwr_state, ctl_rst, irq_out, pme_out, mmio_ack, mmio_abort, dma_gnt, sof_out},
            '0);

        // R2 / R3 directed
        cfg_write(0, 8'h01);
        chk("R2 code 01 ignored", pwr_state, 2'b00);
        cfg_write(0, 8'h00);
        chk("R3 00 from 00 no pulse", ctl_rst, 0);
        cfg_write(0, 8'h03);
        chk("R2 code 11 accepted", pwr_state, 2'b11);
        chk("R3 no pulse on 11", ctl_rst, 0);
        cfg_write(0, 8'h02);
        chk("R2 code 10 ignored", pwr_state, 2'b11);
        cfg_read(0, rd);
        chk("R10 read power", rd, 8'h03);
        cfg_write(0, 8'h00);
        chk("R3 wake reset pulse", {pwr_state, ctl_rst}, {2'b00, 1'b1});
        step();
        chk("R3 pulse one cycle", ctl_rst, 0);

        // R2 R3 R4 R5 random mix
        model = 2'b00;
        for (int i = 0; i < 600; i++) begin
            logic w;
            logic [1:0] c;
            w = ($urandom % 4) == 0;
            c = 2'($urandom);
            cfg_wr = w; cfg_addr = 0; cfg_wdata = {6'b0, c};
            irq_raw = 1'($urandom);
            mmio_req = NSRC'($urandom);
            nxt = next_pwr(model, w, c);
            step();
            chk("R2 random state", pwr_state, nxt);
            chk("R3 random pulse", ctl_rst, w && c == 2'b00 && model == 2'b11);
            chk("R5 random irq", irq_out, irq_raw && nxt == 2'b00);
            chk("R4 random ack", mmio_ack, (nxt == 2'b00) ? mmio_req : '0);
            chk("R4 random abort", mmio_abort, (nxt == 2'b11) ? mmio_req : '0);
            model = nxt;
        end
        cfg_wr = 0; irq_raw = 0; mmio_req = 0;
        step();

        // R4 debug source in off state
        cfg_write(0, 8'h03);
        mmio_req = 2'b10;
        step();
        mmio_req = 0;
        chk("R4 debug abort when off", {mmio_ack, mmio_abort}, {2'b00, 2'b10});

        // R6 wake level
        wake_evt = 1; step(); wake_evt = 0;
        chk("R6 pme set", pme_out, 1);
        step(); step();
        chk("R6 pme held", pme_out, 1);
        cfg_read(1, rd);
        chk("R10 status pme", rd, 8'h01);
        cfg_write(1, 8'h01);
        chk("R6 pme w1c", pme_out, 0);
        wake_evt = 1; step(); wake_evt = 0;
        cfg_write(0, 8'h00);
        chk("R6 pme cleared on return", pme_out, 0);
        wake_evt = 1; step(); wake_evt = 0;
        chk("R6 wake ignored when on", pme_out, 0);

        // R7 R8 pause
        dma_req = 4'b0001; step(); dma_req = 0;
        chk("R7 grant ch0", dma_gnt, 4'b0001);
        step();
        chk("R7 grant single pulse", dma_gnt, 4'b0000);
        cfg_write(1, 8'h04);
        chk("R8 not paused while busy", dma_paused, 0);
        dma_req = 4'b0110;
        for (int k = 0; k < 5; k++) begin
            step();
            chk("R7 no grant paused", dma_gnt, 4'b0000);
        end
        dma_done = 4'b0001; step(); dma_done = 0;
        chk("R8 paused after done", dma_paused, 1);
        cfg_read(1, rd);
        chk("R10 status paused", rd, 8'h06);
        cfg_write(1, 8'h00);
        chk("R8 paused clear", dma_paused, 0);
        step();
        chk("R7 release after clear", dma_gnt, 4'b0110);
        dma_req = 0;
        dma_done = 4'b0110; step(); dma_done = 0;

        // R9 frame start keeps running while paused and off
        cfg_write(1, 8'h04);
        cfg_write(0, 8'h03);
        f0 = frame_num;
        sof_tick = 1; step(); sof_tick = 0;
        chk("R9 sof while paused off", sof_out, 1);
        chk("R9 frame advance", frame_num, f0 + 1'b1);
        step();
        chk("R9 sof pulse ends", sof_out, 0);
        f0 = frame_num;
        sof_tick = 1;
        for (int k = 0; k < (1 << FRAME_W); k++) step();
        sof_tick = 0;
        chk("R9 frame wrap", frame_num, f0);

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule